// File: doc/BRIEF.md
# Delay-Chain Supply Voltage Sensor Decoder

This block sits behind a delay-chain time-to-digital converter that measures on-chip supply voltage. Once per clock cycle, a launched edge travels down a chain of delay cells, and a bank of flip-flops samples every tap of the chain in parallel. The delay of each cell depends on the supply, so the number of taps the edge has reached shows how high the voltage was during that one cycle. A higher supply always gives a larger tap count.

The decoder registers that tap snapshot and finds the reach of the edge. It ignores single-bit bubbles and stray single bits ahead of the front. It then turns the tap count into millivolts through a calibration table that software can rewrite at run time. A fresh, valid voltage comes out every cycle, two edges after the capture register. A sticky flag records any sample in which the edge reached no tap or went past every tap.

Top module: `vsense_decoder`

## Requirements
- R1: While reset is asserted, `volt_vld`, `volt_mv` and `range_flag` are all 0.
- R2: After reset is released, `volt_vld` is 0 after the first and second rising edges, becomes 1 after the third rising edge, and then stays 1 until the next reset.
- R3: The tap vector present at rising edge N gives its voltage on `volt_mv` just after rising edge N+2. Back-to-back samples produce one result per cycle.
- R4: The tap count is found as follows. Tap i (bit i, with bit 0 nearest the launch point) is confirmed when it is 1 and either i is 0 or tap i-1 is also 1. The count is one more than the highest confirmed tap, or 0 when no tap is confirmed. A lone 0 inside a run of 1s therefore does not shorten the count.
- R5: A lone 1 beyond the front, with 0 on both sides of it, is ignored. A run of two or more 1s beyond the front extends the count to the end of that run.
- R6: After reset, table entry c holds 900 + floor(3.9·c) mV, for c from 0 to 256.
- R7: A write with `tbl_we`=1 stores `tbl_data` at entry `tbl_addr`. Later lookups of that count return the new value.
- R8: A lookup made on the same rising edge as a write to the same entry returns the value held before the write.
- R9: If all 256 taps are 1, the count is 256. This returns the value of entry 256 and sets `range_flag`.
- R10: A count of 0 (no confirmed tap) returns entry 0 and sets `range_flag`. Counts from 1 to 255 never set it.
- R11: Once set, `range_flag` stays 1 until reset.
- R12: Writes with `tbl_addr` above 256 change no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; taps captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| taps | input | 256 | Delay-chain flip-flop outputs, bit 0 nearest the launch point |
| tbl_we | input | 1 | Calibration table write enable |
| tbl_addr | input | 9 | Calibration table entry (tap count) to write |
| tbl_data | input | 16 | Millivolt value to store |
| volt_mv | output | 16 | Supply voltage estimate in millivolts |
| volt_vld | output | 1 | Marks `volt_mv` as holding a decoded sample |
| range_flag | output | 1 | Sticky: a sample reached no tap or went past every tap |

## Verification
A wrong encoder state shows up on `volt_mv` exactly two edges later as the table value for the wrong count. Sweeping every clean count from 0 to 256 therefore exposes any off-by-one or lost tap. A table holding corrupt or stale data shows up the first time that count is looked up. The same-edge write case separates a read-before-write table from a write-through one within a single cycle. A flag that sets for an in-range count, or that clears on its own, is visible on `range_flag` one edge after the decoded sample that caused it.

// File: rtl/vsense_pkg.sv
package vsense_pkg;
  localparam int unsigned CAL_BASE_MV  = 900;
  localparam int unsigned CAL_STEP_NUM = 39;
  localparam int unsigned CAL_STEP_DEN = 10;

  // Power-up calibration: linear ramp from the base voltage, step 3.9 mV per tap.
  function automatic int unsigned cal_default_mv(input int unsigned idx);
    return CAL_BASE_MV + (idx * CAL_STEP_NUM) / CAL_STEP_DEN;
  endfunction
endpackage

// File: rtl/vs_edge_encoder.sv
module vs_edge_encoder #(
  parameter int STAGES = 256,
  parameter int CNT_W  = $clog2(STAGES + 1)
) (
  input  logic [STAGES-1:0] taps,
  output logic [CNT_W-1:0]  count
);
  // A tap is confirmed only when it and its predecessor both saw the edge.
  logic [STAGES-1:0] confirmed;

  assign confirmed[0] = taps[0];
  for (genvar i = 1; i < STAGES; i++) begin : g_conf
    assign confirmed[i] = taps[i] & taps[i-1];
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (confirmed[i]) count = CNT_W'(i + 1);
    end
  end
endmodule

// File: rtl/vs_cal_table.sv
module vs_cal_table
  import vsense_pkg::*;
#(
  parameter int ENTRIES = 257,
  parameter int AW      = $clog2(ENTRIES),
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [ENTRIES];
  logic          wr_ok;
  logic          rd_ok;

  assign wr_ok = we && (int'(waddr) < ENTRIES);
  assign rd_ok = rd_en && (int'(raddr) < ENTRIES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= DW'(cal_default_mv(i));
    end else if (wr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  // Registered read on the same edge as the write, so the old entry comes out.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_ok) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vsense_decoder.sv
module vsense_decoder #(
  parameter int STAGES = 256,
  parameter int VOLT_W = 16,
  parameter int CNT_W  = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] taps,
  input  logic              tbl_we,
  input  logic [CNT_W-1:0]  tbl_addr,
  input  logic [VOLT_W-1:0] tbl_data,
  output logic [VOLT_W-1:0] volt_mv,
  output logic              volt_vld,
  output logic              range_flag
);
  localparam int ENTRIES = STAGES + 1;

  logic [STAGES-1:0] cap_q;
  logic              cap_vld;
  logic [CNT_W-1:0]  enc_count;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_vld;
  logic              cnt_extreme;

  // Stage 0: capture the chain snapshot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      cap_vld <= 1'b0;
    end else begin
      cap_q   <= taps;
      cap_vld <= 1'b1;
    end
  end

  vs_edge_encoder #(.STAGES(STAGES), .CNT_W(CNT_W)) u_enc (
    .taps  (cap_q),
    .count (enc_count)
  );

  // Stage 1: register the tap count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cnt_vld <= 1'b0;
    end else begin
      cnt_q   <= enc_count;
      cnt_vld <= cap_vld;
    end
  end

  assign cnt_extreme = (cnt_q == '0) || (cnt_q == CNT_W'(STAGES));

  // Stage 2: calibration lookup.
  vs_cal_table #(.ENTRIES(ENTRIES), .AW(CNT_W), .DW(VOLT_W)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .rd_en (cnt_vld),
    .raddr (cnt_q),
    .rdata (volt_mv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      volt_vld   <= 1'b0;
      range_flag <= 1'b0;
    end else begin
      volt_vld   <= cnt_vld;
      range_flag <= range_flag | (cnt_vld & cnt_extreme);
    end
  end
endmodule

// File: rtl/vsense_decoder_chk.sv
module vsense_decoder_chk #(
  parameter int STAGES = 256,
  parameter int CNT_W  = $clog2(STAGES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             volt_vld,
  input logic             range_flag,
  input logic             cnt_vld,
  input logic [CNT_W-1:0] cnt_q
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!volt_vld && !range_flag));

  p_vld_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    volt_vld |=> volt_vld);

  p_vld_follows_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_vld |=> volt_vld);

  p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(range_flag) |-> ($past(cnt_vld) &&
      ($past(cnt_q) == '0 || $past(cnt_q) == CNT_W'(STAGES))));

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    range_flag |=> range_flag);
endmodule

bind vsense_decoder vsense_decoder_chk #(.STAGES(STAGES), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .volt_vld   (volt_vld),
  .range_flag (range_flag),
  .cnt_vld    (cnt_vld),
  .cnt_q      (cnt_q)
);

// File: tb/vsense_decoder_tb.sv
`timescale 1ns/1ps
module vsense_decoder_tb;
  localparam int N = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  taps = '0;
  logic          tbl_we = 1'b0;
  logic [8:0]    tbl_addr = '0;
  logic [15:0]   tbl_data = '0;
  logic [15:0]   volt_mv;
  logic          volt_vld;
  logic          range_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vsense_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .taps(taps), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .volt_mv(volt_mv), .volt_vld(volt_vld), .range_flag(range_flag)
  );

  always #5 clk = ~clk;

  function automatic int exp_mv(input int c);
    return 900 + 3 * c + (9 * c) / 10;
  endfunction

  function automatic logic [N-1:0] therm(input int c);
    logic [N-1:0] v = '0;
    for (int i = 0; i < c; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input logic [N-1:0] p);
    taps = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 vld", int'(volt_vld), 0);
    check("R1 mv", int'(volt_mv), 0);
    check("R1 flag", int'(range_flag), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int watch = 0;
    while (!done) begin
      @(posedge clk);
      watch++;
      if (watch > 200000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", watch, 200000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] p;
    int seq [8] = '{12, 200, 1, 77, 255, 3, 130, 64};

    // R1 and R2
    taps = therm(10);
    do_reset();
    @(negedge clk); check("R2 vld after edge1", int'(volt_vld), 0);
    @(negedge clk); check("R2 vld after edge2", int'(volt_vld), 0);
    @(negedge clk); check("R2 vld after edge3", int'(volt_vld), 1);
    check("R3 first value", int'(volt_mv), exp_mv(10));

    // R3/R6 sweep of every in-range clean count
    for (int c = 1; c < N; c++) begin
      settle(therm(c));
      check("R6 default table", int'(volt_mv), exp_mv(c));
    end
    check("R10 no flag in range", int'(range_flag), 0);
    check("R2 vld stays", int'(volt_vld), 1);

    // R4 bubble inside the run
    p = therm(40); p[20] = 1'b0;
    settle(p); check("R4 inner bubble", int'(volt_mv), exp_mv(40));
    p = therm(40); p[0] = 1'b0;
    settle(p); check("R4 first tap bubble", int'(volt_mv), exp_mv(40));
    // R5 stray bits ahead of the front
    p = therm(40); p[60] = 1'b1;
    settle(p); check("R5 lone stray", int'(volt_mv), exp_mv(40));
    p = therm(40); p[60] = 1'b1; p[61] = 1'b1;
    settle(p); check("R5 stray pair", int'(volt_mv), exp_mv(62));
    check("R10 bubbles no flag", int'(range_flag), 0);

    // R3 back-to-back stream: result of pattern j read at negedge j+3
    for (int j = 0; j < 11; j++) begin
      if (j >= 3) check("R3 stream latency", int'(volt_mv), exp_mv(seq[j-3]));
      if (j < 8) taps = therm(seq[j]);
      @(negedge clk);
    end

    // R8 then R7: write entry 100 while it is being looked up
    settle(therm(100));
    tbl_we = 1'b1; tbl_addr = 9'd100; tbl_data = 16'd4321;
    @(negedge clk);
    check("R8 old on same edge", int'(volt_mv), exp_mv(100));
    tbl_we = 1'b0;
    @(negedge clk);
    check("R7 new value", int'(volt_mv), 4321);
    settle(therm(99));
    check("R7 neighbour intact", int'(volt_mv), exp_mv(99));
    settle(therm(100));
    check("R7 value retained", int'(volt_mv), 4321);

    // R12 out-of-range write address
    tbl_we = 1'b1; tbl_addr = 9'd300; tbl_data = 16'd7;
    @(negedge clk);
    tbl_we = 1'b0;
    settle(therm(44)); check("R12 alias 44", int'(volt_mv), exp_mv(44));
    settle(therm(43)); check("R12 alias 43", int'(volt_mv), exp_mv(43));

    // R10 all blocked
    settle('0);
    check("R10 zero value", int'(volt_mv), exp_mv(0));
    check("R10 flag set", int'(range_flag), 1);
    p = '0; p[9] = 1'b1;
    settle(p); check("R10 lone bit gives zero", int'(volt_mv), exp_mv(0));

    // R6 reset restores the table, R9 all passed
    do_reset();
    settle(therm(100)); check("R6 restored", int'(volt_mv), exp_mv(100));
    check("R9 flag clear", int'(range_flag), 0);
    settle({N{1'b1}});
    check("R9 full value", int'(volt_mv), exp_mv(256));
    check("R9 flag set", int'(range_flag), 1);
    settle(therm(50));
    check("R11 flag sticky", int'(range_flag), 1);
    check("R11 normal value", int'(volt_mv), exp_mv(50));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule